// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-peripheral SPI master. A host writes one 8-bit setup byte and a receive-delay count while the block is idle. The setup byte selects the serial clock rate, the clock phase and idle level, the bit order, the chip-select polarity and a double-rate option. The host then runs byte transfers through a small handshake. It pulses `start` with a byte on `tx_byte`, watches `busy`, and collects the byte shifted in from the peripheral on `rx_byte` when `done` pulses.

Every transfer is full duplex. While the block drives eight bits out on `mosi`, it captures eight bits from `miso` on the opposite clock edges. Before the first clock edge of each byte, the block can wait a programmable number of extra clock half-periods. During that wait the serial clock stays at its idle level, which gives slow peripherals time to prepare their reply. A `hold` input keeps chip select asserted from one byte to the next, so that multi-byte transactions form one frame.

Top module: `spim_master`

## Requirements
- R1: After reset, `cs` is high (the reset setup byte is zero, so chip select is active low and inactive), `sclk` is low, and `busy`, `done` and `rx_byte` are zero.
- R2: Setup bits 1:0 give the serial clock half-period in system clocks: 2, 8, 32 or 64 for codes 0, 1, 2 and 3. These correspond to clock rates of f/4, f/16, f/64 and f/128.
- R3: When setup bit 7 is set, the half-period chosen by bits 1:0 is halved, to 1, 4, 16 or 32 system clocks.
- R4: Setup bit 3 sets the idle level of `sclk`. Setup bit 2 sets the phase:
  - When bit 2 is 0, the first data bit is on `mosi` before the first clock edge, the block samples `miso` on leading edges and changes `mosi` on trailing edges.
  - When bit 2 is 1, the block changes `mosi` on leading edges and samples `miso` on trailing edges.
  - In all four modes the bytes are exchanged intact.
- R5: Setup bit 5 set to 0 sends and receives the most significant bit first. Set to 1, it sends and receives the least significant bit first.
- R6: Setup bit 6 set to 0 makes chip select active low; set to 1, active high. Loading a setup byte drives chip select to its inactive level.
- R7: Setup bit 4 has no effect: a setup byte with bit 4 set behaves the same as the byte with bit 4 cleared.
- R8: Chip select becomes active one half-period before the first `sclk` edge (when the delay count is zero) and stays active throughout the transfer. It becomes inactive one half-period after the last edge, unless `hold` is high. With `hold` high it stays active until `hold` falls while the block is idle.
- R9: A receive-delay count of d adds d half-periods between chip-select assertion and the first `sclk` edge of every byte. During this wait `sclk` does not move.
- R10: `done` is high for exactly one system clock at the end of each byte, `rx_byte` holds the received byte from that cycle on, and `busy` is high from the cycle after `start` is accepted until `done`.
- R11: A `start` pulse or a `cfg_load` pulse while `busy` is high has no effect. If both arrive in the same idle cycle, the setup load is taken and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Load `cfg_byte` and `cfg_rx_delay` (taken only when idle) |
| cfg_byte | input | 8 | Setup byte: rate, phase, idle level, order, select polarity, double rate |
| cfg_rx_delay | input | DLY_W | Extra half-periods waited before each byte |
| start | input | 1 | Begin a transfer of `tx_byte` |
| hold | input | 1 | Keep chip select asserted after the byte ends |
| tx_byte | input | DATA_W | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rx_byte | output | DATA_W | Last byte received |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select, polarity per setup bit 6 |

## Verification
The assertions rely on a few conditions at the inputs. The setup byte and delay change only through `cfg_load`. The reset is applied for at least one clock before use. `miso` changes only in response to the block's own `sclk` edges. The bench's peripheral model meets these conditions. It updates `miso` only on the falling system clock after the block has moved `sclk`, which keeps it a full half-period away from the block's sampling edge. The stray `start` and `cfg_load` pulses in the busy-window test fall strictly inside a transfer.

// File: rtl/spim_pkg.sv
// Package: shared types and helpers for the SPI master.
// Assumes the setup byte layout is fixed: the bit positions of the struct
// fields are the positions the host writes.
package spim_pkg;

    localparam int HALF_W = 7;

    typedef struct packed {
        logic       dbl;    // bit 7: halve the half-period
        logic       cs_hi;  // bit 6: chip select active high
        logic       lsb;    // bit 5: least significant bit first
        logic       rsvd;   // bit 4: reserved, ignored
        logic       cpol;   // bit 3: sclk idle level
        logic       cpha;   // bit 2: clock phase
        logic [1:0] div;    // bits 1:0: rate code
    } spim_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } spim_state_t;

    // Half-period length in system clocks for a given setup.
    function automatic logic [HALF_W-1:0] half_len_of(input spim_cfg_t c);
        logic [HALF_W-1:0] base;
        unique case (c.div)
            2'd0:    base = HALF_W'(2);
            2'd1:    base = HALF_W'(8);
            2'd2:    base = HALF_W'(32);
            default: base = HALF_W'(64);
        endcase
        return c.dbl ? (base >> 1) : base;
    endfunction

endpackage

// File: rtl/spim_tick.sv
// Module: half-period tick generator.
// Emits a one-cycle tick every half_len system clocks while en is high and
// restarts from zero whenever en is low. Assumes half_len >= 1 and that
// half_len does not change while en is high.
module spim_tick #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half_len,
    output logic              tick
);

    logic [HALF_W-1:0] cnt;

    // Tick fires on the last count of each half-period.
    assign tick = en && (cnt == HALF_W'(half_len - 1'b1));

    // Count system clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: two ticks are never adjacent when a half-period spans several clocks
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && (half_len > HALF_W'(1))) |=> !tick)
        else $error("a_r2_tick_gap");

endmodule

// File: rtl/spim_shift.sv
// Module: transmit and receive shift registers.
// Loads the outgoing byte on load, then acts on each sclk edge reported by
// the controller: one edge class shifts the output, the other samples miso.
// Assumes cpha and lsb are stable for the whole transfer.
module spim_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              edge_fire,
    input  logic              leading,
    input  logic              first,
    input  logic              cpha,
    input  logic              lsb,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] txsr;
    logic              shift_now;
    logic              sample_now;

    // Phase 0 moves data on trailing edges; phase 1 on leading edges after the first.
    assign shift_now  = edge_fire && (cpha ? (leading && !first) : !leading);
    // Sampling uses the edge class that does not move data.
    assign sample_now = edge_fire && (cpha ? !leading : leading);
    // Present the bit at the end selected by the bit order.
    assign mosi       = lsb ? txsr[0] : txsr[DATA_W-1];

    // Outgoing shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsr <= '0;
        end else if (load) begin
            txsr <= tx_data;
        end else if (shift_now) begin
            txsr <= lsb ? (txsr >> 1) : (txsr << 1);
        end
    end

    // Incoming shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (sample_now) begin
            rx_data <= lsb ? {miso, rx_data[DATA_W-1:1]} : {rx_data[DATA_W-2:0], miso};
        end
    end

    // R5: the first bit shown after a load is the end chosen by the bit order
    a_r5_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mosi == ($past(lsb) ? $past(tx_data[0]) : $past(tx_data[DATA_W-1]))))
        else $error("a_r5_first_bit");

endmodule

// File: rtl/spim_master.sv
// Module: SPI master top level.
// Holds the setup byte, sequences chip select, the optional pre-byte wait and
// the sixteen clock edges of a byte, and reports the received byte with a
// one-cycle done pulse. Assumes a single peripheral and that miso changes
// only in response to sclk edges.
module spim_master #(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_byte,
    input  logic [DLY_W-1:0]  cfg_rx_delay,
    input  logic              start,
    input  logic              hold,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs
);
    import spim_pkg::*;

    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES + 1);

    spim_cfg_t           cfg_q;
    spim_cfg_t           cfg_in;
    logic [DLY_W-1:0]    dly_q;
    spim_state_t         state;
    logic [DLY_W-1:0]    wcnt;
    logic [ECNT_W-1:0]   ecnt;
    logic [ECNT_W-1:0]   edge_idx;
    logic                sclk_q;
    logic                cs_act;
    logic                done_q;
    logic [DATA_W-1:0]   rx_q;
    logic [DATA_W-1:0]   rx_data;
    logic [HALF_W-1:0]   half_len;
    logic                tick;
    logic                edge_fire;
    logic                accept;

    // Incoming setup byte with the reserved bit forced to zero.
    always_comb begin
        cfg_in      = spim_cfg_t'(cfg_byte);
        cfg_in.rsvd = 1'b0;
    end

    assign half_len  = half_len_of(cfg_q);
    assign busy      = (state != ST_IDLE);
    assign accept    = (state == ST_IDLE) && start && !cfg_load;
    assign edge_fire = tick && (((state == ST_WAIT) && (wcnt == '0)) ||
                                ((state == ST_SHIFT) && (ecnt != ECNT_W'(EDGES))));
    assign edge_idx  = (state == ST_WAIT) ? '0 : ecnt;
    assign done      = done_q;
    assign rx_byte   = rx_q;
    assign sclk      = sclk_q;
    assign cs        = cfg_q.cs_hi ? cs_act : !cs_act;

    spim_tick #(
        .HALF_W (HALF_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .half_len (half_len),
        .tick     (tick)
    );

    spim_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_data   (tx_byte),
        .edge_fire (edge_fire),
        .leading   (!edge_idx[0]),
        .first     (edge_idx == '0),
        .cpha      (cfg_q.cpha),
        .lsb       (cfg_q.lsb),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );

    // Transfer sequencer: setup, chip select, wait, edges and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            dly_q  <= '0;
            state  <= ST_IDLE;
            wcnt   <= '0;
            ecnt   <= '0;
            sclk_q <= 1'b0;
            cs_act <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cfg_load) begin
                        cfg_q  <= cfg_in;
                        dly_q  <= cfg_rx_delay;
                        sclk_q <= cfg_in.cpol;
                        cs_act <= 1'b0;
                    end else if (start) begin
                        state  <= ST_WAIT;
                        wcnt   <= dly_q;
                        cs_act <= 1'b1;
                    end else if (!hold) begin
                        cs_act <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (wcnt == '0) begin
                            state  <= ST_SHIFT;
                            ecnt   <= ECNT_W'(1);
                            sclk_q <= !sclk_q;
                        end else begin
                            wcnt <= wcnt - 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (ecnt == ECNT_W'(EDGES)) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            rx_q   <= rx_data;
                            if (!hold) begin
                                cs_act <= 1'b0;
                            end
                        end else begin
                            ecnt   <= ecnt + 1'b1;
                            sclk_q <= !sclk_q;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: done never lasts more than one clock
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("a_r10_done_single");

    // R11: the setup cannot change in a cycle that follows a busy cycle
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(cfg_q))
        else $error("a_r11_cfg_frozen");

    // R8: chip select is active whenever a transfer is running
    a_r8_cs_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cs_act)
        else $error("a_r8_cs_active_busy");

    // R9: sclk stays put while delay half-periods remain
    a_r9_sclk_still_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && (wcnt != '0)) |=> $stable(sclk_q))
        else $error("a_r9_sclk_still_in_wait");

    // R4: between transfers sclk rests at the configured idle level
    a_r4_sclk_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sclk_q == cfg_q.cpol))
        else $error("a_r4_sclk_idle_level");

endmodule

// File: tb/tb_spim_master.sv
module tb_spim_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic [7:0] cfg_rx_delay = '0;
    logic       start = 1'b0;
    logic       hold = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       busy;
    logic       done;
    logic [7:0] rx_byte;
    logic       sclk;
    logic       mosi;
    logic       miso = 1'b0;
    logic       cs;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] cur_cfg = '0;
    int cur_dly = 0;

    always #4 clk = ~clk;

    spim_master dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_byte     (cfg_byte),
        .cfg_rx_delay (cfg_rx_delay),
        .start        (start),
        .hold         (hold),
        .tx_byte      (tx_byte),
        .busy         (busy),
        .done         (done),
        .rx_byte      (rx_byte),
        .sclk         (sclk),
        .mosi         (mosi),
        .miso         (miso),
        .cs           (cs)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int half_exp(input logic [7:0] c);
        int b;
        case (c[1:0])
            2'd0: b = 2;
            2'd1: b = 8;
            2'd2: b = 32;
            default: b = 64;
        endcase
        return c[7] ? b / 2 : b;
    endfunction

    function automatic logic bit_of(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    task automatic load_cfg(input logic [7:0] c, input int d);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_byte = c;
        cfg_rx_delay = 8'(d);
        @(negedge clk);
        cfg_load = 1'b0;
        cur_cfg = c;
        cur_dly = d;
    endtask

    // One byte with a peripheral model; measures timing at negative clock edges.
    task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx,
                        input logic use_hold, input logic poke,
                        output logic [7:0] sgot, output int first_dly,
                        output int gmin, output int gmax, output int tail,
                        output int ndone, output logic wide, output logic cs_ok);
        logic cpha, cpol, lsb, cshi, prev_sclk, prev_done;
        int cyc, last_edge, outk, ink, after;
        bit fin;
        cpha = cur_cfg[2]; cpol = cur_cfg[3]; lsb = cur_cfg[5]; cshi = cur_cfg[6];
        cyc = 0; last_edge = -1; outk = 0; ink = 0; after = 0; fin = 0;
        prev_done = 1'b0;
        gmin = 1000000; gmax = 0; ndone = 0; wide = 1'b0; first_dly = -1;
        tail = -1; sgot = '0; cs_ok = 1'b1;
        @(negedge clk);
        tx_byte = mtx;
        hold = use_hold;
        start = 1'b1;
        prev_sclk = sclk;
        @(negedge clk);
        start = 1'b0;
        if (cs !== cshi) cs_ok = 1'b0;
        if (!cpha) begin
            miso = bit_of(stx, 0, lsb);
            outk = 1;
        end
        while (!fin && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (sclk !== prev_sclk) begin
                if (last_edge < 0) begin
                    first_dly = cyc;
                end else begin
                    if (cyc - last_edge < gmin) gmin = cyc - last_edge;
                    if (cyc - last_edge > gmax) gmax = cyc - last_edge;
                end
                last_edge = cyc;
                if ((sclk !== cpol) == !cpha) begin
                    if (ink < 8) sgot[lsb ? ink : 7 - ink] = mosi;
                    ink++;
                end else begin
                    if (outk < 8) miso = bit_of(stx, outk, lsb);
                    outk++;
                end
                prev_sclk = sclk;
            end
            if (done) begin
                ndone++;
                if (prev_done) wide = 1'b1;
            end
            prev_done = done;
            if (busy && cs !== cshi) cs_ok = 1'b0;
            if (!use_hold && tail < 0 && last_edge >= 0 && cs !== cshi)
                tail = cyc - last_edge;
            if (ndone > 0) begin
                after++;
                if (after == 4) fin = 1;
            end
            if (poke && cyc == 5) begin
                start = 1'b1; tx_byte = ~mtx; cfg_load = 1'b1; cfg_byte = 8'h4B;
            end else if (poke && cyc == 6) begin
                start = 1'b0; cfg_load = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        check(cs === 1'b1, "R1", "cs after reset", int'(cs), 1);
        check(sclk === 1'b0, "R1", "sclk after reset", int'(sclk), 0);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset",
              int'({busy, done}), 0);
        check(rx_byte === 8'h00, "R1", "rx_byte after reset", int'(rx_byte), 0);
    endtask

    // R4: all four modes exchange bytes and leave sclk idle; R10 done single cycle.
    task automatic t_modes();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        for (int m = 0; m < 4; m++) begin
            logic [7:0] mt, st;
            mt = 8'hA5 ^ 8'(m * 17);
            st = 8'h3C + 8'(m * 29);
            load_cfg(8'(m << 2), 0);
            check(sclk === cur_cfg[3], "R4", "sclk idle level", int'(sclk), int'(cur_cfg[3]));
            xfer(mt, st, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
            check(got === mt, "R4", $sformatf("mode %0d peripheral got", m), int'(got), int'(mt));
            check(rx_byte === st, "R4", $sformatf("mode %0d rx_byte", m), int'(rx_byte), int'(st));
            check(sclk === cur_cfg[3], "R4", "sclk idle after byte", int'(sclk), int'(cur_cfg[3]));
            check(nd == 1 && !wd, "R10", "single one-cycle done", nd, 1);
        end
    endtask

    task automatic t_order();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h20, 0);
        xfer(8'h81, 8'h16, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(got === 8'h81 && rx_byte === 8'h16, "R5", "lsb first mode 0",
              int'({got, rx_byte}), int'({8'h81, 8'h16}));
        load_cfg(8'h2C, 0);
        xfer(8'h4E, 8'hD1, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(got === 8'h4E && rx_byte === 8'hD1, "R5", "lsb first mode 3",
              int'({got, rx_byte}), int'({8'h4E, 8'hD1}));
    endtask

    task automatic t_rates();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] c;
            c = {k[2], 5'b0, k[1:0]};
            load_cfg(c, 0);
            xfer(8'h5A, 8'hC3, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
            check(gmn == half_exp(c) && gmx == half_exp(c), k[2] ? "R3" : "R2",
                  $sformatf("half-period cfg %02h", c), gmx, half_exp(c));
            check(got === 8'h5A && rx_byte === 8'hC3, k[2] ? "R3" : "R2",
                  "data at this rate", int'(rx_byte), 8'hC3);
        end
    endtask

    task automatic t_cs();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h41, 0);
        check(cs === 1'b0, "R6", "active-high cs idle after load", int'(cs), 0);
        xfer(8'h69, 8'h96, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(ok, "R6", "cs high during transfer", int'(ok), 1);
        check(fd == 8, "R8", "cs to first edge", fd, 8);
        check(tl == 8, "R8", "last edge to cs release", tl, 8);
        check(cs === 1'b0, "R6", "cs idle after transfer", int'(cs), 0);
        load_cfg(8'h01, 0);
        check(cs === 1'b1, "R6", "active-low cs idle after load", int'(cs), 1);
    endtask

    task automatic t_reserved();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h15, 0);
        xfer(8'hE7, 8'h18, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(gmx == 8 && gmn == 8, "R7", "rate with bit 4 set", gmx, 8);
        check(got === 8'hE7 && rx_byte === 8'h18 && cs === 1'b1, "R7",
              "mode 1 exchange with bit 4 set", int'(rx_byte), 8'h18);
    endtask

    task automatic t_delay();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h00, 3);
        xfer(8'h33, 8'hCC, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(fd == 8, "R9", "delay 3 at half 2", fd, 8);
        check(rx_byte === 8'hCC, "R9", "data with delay", int'(rx_byte), 8'hCC);
        load_cfg(8'h81, 5);
        xfer(8'h0F, 8'hF0, 1'b0, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(fd == 24, "R9", "delay 5 at half 4", fd, 24);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h00, 0);
        xfer(8'h9C, 8'h27, 1'b0, 1'b1, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(nd == 1, "R11", "one done despite stray start", nd, 1);
        check(got === 8'h9C && rx_byte === 8'h27, "R11", "data unchanged by stray start",
              int'(got), 8'h9C);
        check(gmx == 2 && ok && cs === 1'b1, "R11", "setup unchanged by stray load", gmx, 2);
        // Same-cycle load and start: load wins, no transfer starts.
        @(negedge clk);
        cfg_load = 1'b1; cfg_byte = 8'h08; cfg_rx_delay = 8'd0; start = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; start = 1'b0; cur_cfg = 8'h08;
        check(busy === 1'b0 && sclk === 1'b1, "R11", "load beats start",
              int'({busy, sclk}), 1);
    endtask

    task automatic t_hold();
        logic [7:0] got; int fd, gmn, gmx, tl, nd; logic wd, ok;
        load_cfg(8'h00, 0);
        xfer(8'h11, 8'h22, 1'b1, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(cs === 1'b0, "R8", "cs kept by hold", int'(cs), 0);
        xfer(8'h44, 8'h88, 1'b1, 1'b0, got, fd, gmn, gmx, tl, nd, wd, ok);
        check(cs === 1'b0 && rx_byte === 8'h88, "R8", "second held byte",
              int'(rx_byte), 8'h88);
        @(negedge clk);
        hold = 1'b0;
        @(negedge clk);
        check(cs === 1'b1, "R8", "cs released when hold falls", int'(cs), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_order();
        t_rates();
        t_cs();
        t_reserved();
        t_delay();
        t_busy_ignore();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule